// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block sits between a group of maskable interrupt sources and a small CPU core. Each source owns a control register that holds a 3-bit priority level and a pending flag. A hardware event on the source's request line sets the pending flag. Software can program the level and can cancel a pending request, but it can never raise one. The block also holds a global enable flag and a 3-bit processor priority level.

On every cycle the block looks for the sources that are eligible, picks the strongest one and registers the result. The core sees a request line and the index of the winning source. When the core takes the interrupt and branches, it pulses an acknowledge. That pulse clears the pending flag of the presented source.

Software reaches all registers through one write port. Addresses 0 to NUM_SRC-1 select the source control registers. Address NUM_SRC holds the processor level in data bits 2:0. Address NUM_SRC+1 holds the global enable in data bit 0. Writes to any other address are ignored.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every level, every pending flag, the processor level and the global enable are 0, irq_req_o is 0 and irq_idx_o is 0.
- R2: A high bit of src_evt_i in a cycle sets that source's pending flag at the following edge, and the flag stays set until it is cleared.
- R3: A source whose level field is 0 is never presented, even when it is pending.
- R4: While the global enable is 0, irq_req_o stays 0 whatever the levels and pending flags are.
- R5: A pending source is eligible only when its level is strictly greater than the processor level. A processor level of 7 therefore blocks every source.
- R6: Among the eligible sources the highest level wins, and a tie at equal level goes to the lowest index. When no source is eligible, irq_idx_o reads 0.
- R7: When irq_ack_i is high while irq_req_o is high, the pending flag of the source named by irq_idx_o clears at that edge.
- R8: A write to a source register loads its level from data bits 2:0. Data bit 3 = 0 clears the pending flag, and bit 3 = 1 leaves the flag unchanged, so a write never sets it.
- R9: A hardware event wins over a software clear and over an acknowledge of the same source in the same cycle, so the flag stays set.
- R10: A write to the processor level, to the global enable, to one source register, or to an unused address leaves every other register unchanged.
- R11: The arbitration result is registered. irq_req_o and irq_idx_o follow a register or pending-flag change one cycle after the edge that made the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | NUM_SRC | Hardware request events, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | $clog2(NUM_SRC+2) | Register write address |
| wr_data_i | input | 4 | Register write data |
| irq_ack_i | input | 1 | Single-cycle acknowledge from the core |
| irq_req_o | output | 1 | An eligible request is presented |
| irq_idx_o | output | $clog2(NUM_SRC) | Index of the presented source |

## Verification
A table of vectors sets fixed levels and then varies the set of pending sources, the processor level and the enable. The vectors separate a strict from a non-strict level comparison, a tie broken by the lowest index from one broken by the highest index, and level 0 from level 1. They also cover a processor level of 7 and a disabled global gate. Directed sequences then check the acknowledge path and the one-cycle stale output that follows an acknowledge. They also check that a write with the pending bit at 1 sets nothing, that a hardware event wins over a clear or an acknowledge in the same cycle, and that writes to the processor level, to the enable and to unused addresses leave the pending state alone.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned DATA_W   = 4;
  localparam int unsigned PEND_BIT = 3;
  localparam int unsigned EN_BIT   = 0;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_src_reg.sv
module irq_src_reg
  import irq_prio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              ack_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output lvl_t              lvl_o,
  output logic              pend_o
);
  lvl_t lvl_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_i) lvl_q <= wr_data_i[LVL_W-1:0];
      // hardware set wins so no request is lost
      if (evt_i) pend_q <= 1'b1;
      else if (ack_i || (wr_i && !wr_data_i[PEND_BIT])) pend_q <= 1'b0;
    end
  end

  assign lvl_o  = lvl_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                en_i,
  input  lvl_t                cpu_lvl_i,
  input  logic [NUM_SRC-1:0]  pend_i,
  input  lvl_t [NUM_SRC-1:0]  lvl_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = en_i & pend_i[g] & (lvl_i[g] > cpu_lvl_i);
  end

  lvl_t best;
  always_comb begin
    best  = '0;
    hit_o = 1'b0;
    idx_o = '0;
    // strict compare keeps the lowest index on a tie
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (lvl_i[i] > best)) begin
        best  = lvl_i[i];
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned ADDR_W = $clog2(NUM_SRC + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               irq_ack_i,
  output logic               irq_req_o,
  output logic [IDX_W-1:0]   irq_idx_o
);
  localparam int unsigned ADDR_CPU = NUM_SRC;
  localparam int unsigned ADDR_EN  = NUM_SRC + 1;

  lvl_t               cpu_lvl_q;
  logic               glb_en_q;
  logic [NUM_SRC-1:0] pend_q;
  lvl_t [NUM_SRC-1:0] lvl_q;
  logic               irq_req_q;
  logic [IDX_W-1:0]   irq_idx_q;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               ack_ok;

  assign ack_ok = irq_ack_i & irq_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_lvl_q <= '0;
      glb_en_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_CPU)) cpu_lvl_q <= wr_data_i[LVL_W-1:0];
      if (wr_addr_i == ADDR_W'(ADDR_EN))  glb_en_q  <= wr_data_i[EN_BIT];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_reg u_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (src_evt_i[g]),
      .ack_i     (ack_ok && (irq_idx_q == IDX_W'(g))),
      .wr_i      (wr_en_i && (wr_addr_i == ADDR_W'(g))),
      .wr_data_i (wr_data_i),
      .lvl_o     (lvl_q[g]),
      .pend_o    (pend_q[g])
    );
  end

  irq_arbiter #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
  ) u_arb (
    .en_i      (glb_en_q),
    .cpu_lvl_i (cpu_lvl_q),
    .pend_i    (pend_q),
    .lvl_i     (lvl_q),
    .hit_o     (hit),
    .idx_o     (hit_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_req_q <= 1'b0;
      irq_idx_q <= '0;
    end else begin
      irq_req_q <= hit;
      irq_idx_q <= hit ? hit_idx : '0;
    end
  end

  assign irq_req_o = irq_req_q;
  assign irq_idx_o = irq_idx_q;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_evt_i,
  input logic               irq_ack_i,
  input logic               irq_req_o,
  input logic [IDX_W-1:0]   irq_idx_o,
  input logic [NUM_SRC-1:0] pend_i,
  input lvl_t [NUM_SRC-1:0] lvl_i,
  input lvl_t               cpu_lvl_i,
  input logic               en_i
);
  logic [NUM_SRC-1:0] elig_v;
  logic [NUM_SRC-1:0] elig_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_e
    assign elig_v[g] = en_i && pend_i[g] && (lvl_i[g] > cpu_lvl_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_q <= '0;
    else         elig_q <= elig_v;
  end

  p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_evt_i != '0) |=> ((pend_i & $past(src_evt_i)) == $past(src_evt_i)));

  p_sw_no_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~$past(pend_i) & ~$past(src_evt_i)) == '0));

  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o && !src_evt_i[irq_idx_o]) |=> !pend_i[$past(irq_idx_o)]);

  p_gate_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_req_o);

  p_req_eligible_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> elig_q[irq_idx_o]);

  p_req_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o == (elig_q != '0));

  p_idle_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> (irq_idx_o == '0));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_evt_i (src_evt_i),
  .irq_ack_i (irq_ack_i),
  .irq_req_o (irq_req_o),
  .irq_idx_o (irq_idx_o),
  .pend_i    (pend_q),
  .lvl_i     (lvl_q),
  .cpu_lvl_i (cpu_lvl_q),
  .en_i      (glb_en_q)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  localparam int N      = 8;
  localparam int IDX_W  = 3;
  localparam int ADDR_W = 4;

  typedef struct packed {
    logic [7:0] mask;
    logic [2:0] cpu;
    logic       en;
    logic       req;
    logic [2:0] idx;
    logic [3:0] tag;
  } vec_t;

  // source levels used by the vector table
  localparam logic [2:0] LVLS [N] = '{3'd3, 3'd5, 3'd5, 3'd0, 3'd7, 3'd2, 3'd1, 3'd6};

  localparam vec_t VECS [14] = '{
    '{8'h01, 3'd0, 1'b1, 1'b1, 3'd0, 4'd2},
    '{8'h06, 3'd0, 1'b1, 1'b1, 3'd1, 4'd6},
    '{8'h06, 3'd5, 1'b1, 1'b0, 3'd0, 4'd5},
    '{8'h06, 3'd4, 1'b1, 1'b1, 3'd1, 4'd5},
    '{8'h08, 3'd0, 1'b1, 1'b0, 3'd0, 4'd3},
    '{8'hFF, 3'd0, 1'b1, 1'b1, 3'd4, 4'd6},
    '{8'hFF, 3'd7, 1'b1, 1'b0, 3'd0, 4'd5},
    '{8'hFF, 3'd6, 1'b1, 1'b1, 3'd4, 4'd5},
    '{8'hEF, 3'd0, 1'b1, 1'b1, 3'd7, 4'd6},
    '{8'hFF, 3'd0, 1'b0, 1'b0, 3'd0, 4'd4},
    '{8'h60, 3'd1, 1'b1, 1'b1, 3'd5, 4'd5},
    '{8'h40, 3'd1, 1'b1, 1'b0, 3'd0, 4'd5},
    '{8'h40, 3'd0, 1'b1, 1'b1, 3'd6, 4'd5},
    '{8'hA0, 3'd6, 1'b1, 1'b0, 3'd0, 4'd5}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      evt = '0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [3:0]        wr_data = '0;
  logic              ack = 1'b0;
  logic              irq_req;
  logic [IDX_W-1:0]  irq_idx;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .src_evt_i (evt),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .irq_ack_i (ack),
    .irq_req_o (irq_req),
    .irq_idx_o (irq_idx)
  );

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic er, logic [IDX_W-1:0] ei);
    n_chk++;
    if (irq_req !== er || irq_idx !== ei) begin
      n_err++;
      $display("FAIL %s: req=%0b idx=%0d, expected req=%0b idx=%0d",
               tag, irq_req, irq_idx, er, ei);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(int a, logic [3:0] d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic clear_all();
    for (int s = 0; s < N; s++) wr(s, {1'b0, LVLS[s]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", 1'b0, '0);

    // levels are 0 after reset: pending alone gives nothing
    pulse('1);
    wr(N + 1, 4'h1);
    @(negedge clk);
    check("R3 R1 level0 after reset", 1'b0, '0);
    wr(2, 4'b1100);  // level 4, keep pending
    @(negedge clk);
    check("R2 pending kept across level write", 1'b1, 3'd2);

    // table walk
    for (int v = 0; v < 14; v++) begin
      clear_all();
      wr(N, {1'b0, VECS[v].cpu});
      wr(N + 1, {3'b0, VECS[v].en});
      pulse(VECS[v].mask);
      @(negedge clk);
      check(tag_name(VECS[v].tag), VECS[v].req, VECS[v].idx);
    end

    // R11: one-cycle latency after a register write
    clear_all();
    wr(N, 4'd0);
    wr(N + 1, 4'd0);
    pulse(8'h90);        // src4 lvl7, src7 lvl6
    wr(N + 1, 4'h1);     // enable captured at this edge
    check("R11 not yet", 1'b0, '0);
    @(negedge clk);
    check("R11 one cycle later", 1'b1, 3'd4);

    // R7: acknowledge clears the presented source
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R11 stale after ack", 1'b1, 3'd4);
    @(negedge clk);
    check("R7 next source after ack", 1'b1, 3'd7);

    // R9: event and ack on the same source in one cycle
    ack = 1'b1; evt = 8'h80;
    @(negedge clk);
    ack = 1'b0; evt = '0;
    @(negedge clk);
    check("R9 event beats ack", 1'b1, 3'd7);

    // R9: event and software clear in one cycle
    evt = 8'h80;
    wr(7, {1'b0, 3'd6});
    evt = '0;
    @(negedge clk);
    check("R9 event beats sw clear", 1'b1, 3'd7);

    // R8: software clear, then a write of 1 must not set
    wr(7, {1'b0, 3'd6});
    @(negedge clk);
    check("R8 sw clear", 1'b0, '0);
    wr(7, {1'b1, 3'd6});
    @(negedge clk);
    check("R8 write of 1 sets nothing", 1'b0, '0);

    // R10: other registers leave pending state alone
    pulse(8'h02);        // src1 lvl5
    @(negedge clk);
    check("R10 setup", 1'b1, 3'd1);
    wr(N + 1, 4'h0);
    wr(N, 4'd7);
    @(negedge clk);
    check("R4 gate off", 1'b0, '0);
    wr(N, 4'd0);
    wr(N + 1, 4'h1);
    wr(15, 4'h0);        // unused address
    wr(3, 4'b0000);      // neighbour source register
    @(negedge clk);
    check("R10 pending survives other writes", 1'b1, 3'd1);

    // R8: level field rewritten while pending stays
    wr(1, {1'b1, 3'd3});
    @(negedge clk);
    check("R8 pending kept, level 3", 1'b1, 3'd1);
    wr(N, 4'd3);
    @(negedge clk);
    check("R5 level equal to cpu level", 1'b0, '0);
    wr(N, 4'd2);
    @(negedge clk);
    check("R5 level above cpu level", 1'b1, 3'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule